// File: doc/BRIEF.md
# Wireless MAC Receive Frame Filter

This block takes one already-parsed 802.11 header at a time and decides whether the frame is kept or discarded. The header fields arrive through a valid/ready handshake. They are the two frame-type bits, the ToDS and FromDS bits, the power-management bit, the receiver address (address 1), address 3 and the BSSID. The block applies per-type accept enables and a power-management gate. It applies an address rule to unicast and group frames, including a third-address rule for group traffic that is used only on an infrastructure link.

For every header it returns a registered decision together with three address-class flags: broadcast, multicast, and "addressed to this station". When BSSID checking is on, it also keeps a sticky link-on indication. Link-on is raised by the first header whose BSSID equals the programmed one and whose distribution-system bits fit the current network type. The upstream parser feeds one header per cycle. The downstream receive path reads the result on the cycle after the handshake.

Top module: `wmac_rx_filter`

## Requirements
- R1: Frame type code 0 is management, 1 is control, 2 is data and 3 is reserved. A frame of types 0 to 2 is accepted only when that type's enable (`en_mgmt`, `en_ctrl`, `en_data`) is set. A reserved-type frame is never accepted.
- R2: A frame whose power-management bit is set is dropped unless `en_pwr` is 1. With the bit clear, `en_pwr` has no effect on the decision.
- R3: Address octet 0 lies in bits [7:0] of an address bus, and its bit 0 (bus bit 0) is the group bit. `res_bcast` is 1 exactly when address 1 is all ones. `res_mcast` is 1 exactly when bus bit 0 of address 1 is set and the address is not all ones.
- R4: `res_own` is 1 exactly when address 1 equals `own_mac`. A non-group frame passes the address rule only when `res_own` would be 1.
- R5: A broadcast or multicast frame passes the address rule unconditionally, except when `net_type` is 2 (infrastructure) and `en_grp_a3` is 1. In that case it passes only if address 3 equals `own_mac`.
- R6: With `en_bss_chk` at 1, a handshaken header whose BSSID equals `bss_id` sets `link_on` on the next clock edge, provided its ToDS/FromDS bits are allowed for the network type. The allowed pairs are 0/0 for code 1 (ad-hoc), 0/1 for code 2 (infrastructure) and 1/0 for code 3 (access point). Any other header leaves `link_on` unchanged.
- R7: `link_on` is sticky. Later non-matching headers do not clear it. It clears on the clock edge after `net_type` is sampled as 0 (no link), and clearing takes priority over setting.
- R8: `hdr_rdy` is 0 in reset and 1 from the first clock edge after reset. A handshake at edge k makes `res_vld` 1 for exactly the following cycle, with the decision and flags for that header. `res_vld` is 0 after an edge with no handshake.
- R9: During reset, `hdr_rdy`, `res_vld`, `res_acc`, `res_mcast`, `res_bcast`, `res_own` and `link_on` are all 0.
- R10: With `en_bss_chk` at 0, no header sets `link_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_mgmt | input | 1 | Accept management frames |
| en_ctrl | input | 1 | Accept control frames |
| en_data | input | 1 | Accept data frames |
| en_pwr | input | 1 | Accept frames with the power-management bit set |
| en_grp_a3 | input | 1 | Third-address rule for group frames (infrastructure only) |
| en_bss_chk | input | 1 | Enable BSSID / link-on tracking |
| net_type | input | 2 | 0 no link, 1 ad-hoc, 2 infrastructure, 3 access point |
| own_mac | input | 48 | Station MAC address |
| bss_id | input | 48 | Programmed BSSID |
| hdr_vld | input | 1 | Header valid |
| hdr_rdy | output | 1 | Header ready |
| hdr_type | input | 2 | Frame type code |
| hdr_to_ds | input | 1 | ToDS bit |
| hdr_from_ds | input | 1 | FromDS bit |
| hdr_pwr | input | 1 | Power-management bit |
| hdr_a1 | input | 48 | Address 1 (receiver) |
| hdr_a3 | input | 48 | Address 3 |
| hdr_bss | input | 48 | Received BSSID |
| res_vld | output | 1 | Result valid, one cycle per header |
| res_acc | output | 1 | Frame accepted |
| res_mcast | output | 1 | Address 1 is multicast |
| res_bcast | output | 1 | Address 1 is broadcast |
| res_own | output | 1 | Address 1 equals own MAC |
| link_on | output | 1 | Sticky link-on indication |

## Verification
Every result comes out of one register stage. The decision, the three flags and `res_vld` for a header handshaken at a rising edge are all visible after that same edge. A `link_on` set or clear caused by a header or by `net_type` also appears after the edge that samples it. The bench drives inputs on the falling edge and checks the outputs on the next falling edge, which is exactly one register stage later. Each header is checked in the cycle its result is valid, before the next header replaces it. For link tracking, the bench also samples once more after an idle cycle or after a zero network type, to confirm that the level holds or clears.

// File: rtl/wmac_rx_filter.sv
module wmac_rx_filter #(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_mgmt,
  input  logic          en_ctrl,
  input  logic          en_data,
  input  logic          en_pwr,
  input  logic          en_grp_a3,
  input  logic          en_bss_chk,
  input  logic [1:0]    net_type,
  input  logic [AW-1:0] own_mac,
  input  logic [AW-1:0] bss_id,
  input  logic          hdr_vld,
  output logic          hdr_rdy,
  input  logic [1:0]    hdr_type,
  input  logic          hdr_to_ds,
  input  logic          hdr_from_ds,
  input  logic          hdr_pwr,
  input  logic [AW-1:0] hdr_a1,
  input  logic [AW-1:0] hdr_a3,
  input  logic [AW-1:0] hdr_bss,
  output logic          res_vld,
  output logic          res_acc,
  output logic          res_mcast,
  output logic          res_bcast,
  output logic          res_own,
  output logic          link_on
);
  localparam logic [1:0] NT_NONE  = 2'd0;
  localparam logic [1:0] NT_ADHOC = 2'd1;
  localparam logic [1:0] NT_INFRA = 2'd2;
  localparam logic [1:0] NT_AP    = 2'd3;
  localparam logic [1:0] FT_MGMT  = 2'd0;
  localparam logic [1:0] FT_CTRL  = 2'd1;
  localparam logic [1:0] FT_DATA  = 2'd2;

  logic hs, is_bc, is_mc, own_hit, type_ok, pwr_ok, grp_ok, addr_ok, ds_ok, bss_hit, acc_c;

  assign hs      = hdr_vld & hdr_rdy;
  assign is_bc   = &hdr_a1;
  assign is_mc   = hdr_a1[0] & ~is_bc;
  assign own_hit = (hdr_a1 == own_mac);
  assign bss_hit = (hdr_bss == bss_id);
  assign pwr_ok  = ~hdr_pwr | en_pwr;
  assign grp_ok  = ~((net_type == NT_INFRA) & en_grp_a3) | (hdr_a3 == own_mac);
  assign addr_ok = hdr_a1[0] ? grp_ok : own_hit;
  assign acc_c   = type_ok & pwr_ok & addr_ok;

  always_comb begin
    case (hdr_type)
      FT_MGMT: type_ok = en_mgmt;
      FT_CTRL: type_ok = en_ctrl;
      FT_DATA: type_ok = en_data;
      default: type_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (net_type)
      NT_ADHOC: ds_ok = ~hdr_to_ds & ~hdr_from_ds;
      NT_INFRA: ds_ok = ~hdr_to_ds &  hdr_from_ds;
      NT_AP:    ds_ok =  hdr_to_ds & ~hdr_from_ds;
      default:  ds_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_rdy   <= 1'b0;
      res_vld   <= 1'b0;
      res_acc   <= 1'b0;
      res_mcast <= 1'b0;
      res_bcast <= 1'b0;
      res_own   <= 1'b0;
      link_on   <= 1'b0;
    end else begin
      hdr_rdy <= 1'b1;
      res_vld <= hs;
      if (hs) begin
        res_acc   <= acc_c;
        res_mcast <= is_mc;
        res_bcast <= is_bc;
        res_own   <= own_hit;
      end
      if (net_type == NT_NONE)
        link_on <= 1'b0;
      else if (hs & en_bss_chk & bss_hit & ds_ok)
        link_on <= 1'b1;
    end
  end

  // R8
  res_follows_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_vld && hdr_rdy) |=> res_vld);
  // R8
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_vld && hdr_rdy) |=> !res_vld);
  // R3
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> !(res_mcast && res_bcast));
  // R4
  ucast_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_acc && !res_mcast && !res_bcast) |-> res_own);
  // R2
  pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_acc) |-> (!$past(hdr_pwr) || $past(en_pwr)));
  // R7
  link_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (net_type == NT_NONE) |=> !link_on);
  // R10
  link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_on) |-> $past(hdr_vld && hdr_rdy && en_bss_chk));
endmodule

// File: tb/test_wmac_rx_filter.sv
`timescale 1ns/1ps
module test_wmac_rx_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_mgmt = 0, en_ctrl = 0, en_data = 0, en_pwr = 0, en_grp_a3 = 0, en_bss_chk = 0;
  logic [1:0] net_type = 2'd0;
  logic [47:0] own_mac = 48'h665544332210;
  logic [47:0] bss_id  = 48'hA1B2C3D4E5F0;
  logic hdr_vld = 0;
  logic hdr_rdy;
  logic [1:0] hdr_type = 0;
  logic hdr_to_ds = 0, hdr_from_ds = 0, hdr_pwr = 0;
  logic [47:0] hdr_a1 = 0, hdr_a3 = 0, hdr_bss = 0;
  logic res_vld, res_acc, res_mcast, res_bcast, res_own, link_on;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wmac_rx_filter i_wmac_rx_filter (
    .clk, .rst_n, .en_mgmt, .en_ctrl, .en_data, .en_pwr, .en_grp_a3, .en_bss_chk,
    .net_type, .own_mac, .bss_id, .hdr_vld, .hdr_rdy, .hdr_type, .hdr_to_ds,
    .hdr_from_ds, .hdr_pwr, .hdr_a1, .hdr_a3, .hdr_bss, .res_vld, .res_acc,
    .res_mcast, .res_bcast, .res_own, .link_on);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] addr_of(input int cls);
    case (cls)
      0: return 48'h665544332210;
      1: return 48'h665544332220;
      2: return 48'h5E0000000001;
      default: return 48'hFFFFFFFFFFFF;
    endcase
  endfunction

  task automatic push(input logic [1:0] ft, input logic to, input logic fr, input logic pw,
                      input logic [47:0] a1, input logic [47:0] a3, input logic [47:0] bs);
    hdr_vld = 1; hdr_type = ft; hdr_to_ds = to; hdr_from_ds = fr; hdr_pwr = pw;
    hdr_a1 = a1; hdr_a3 = a3; hdr_bss = bs;
    @(negedge clk);
    hdr_vld = 0;
  endtask

  task automatic link_case(input logic [1:0] nt, input logic to, input logic fr,
                           input logic bmatch, input logic chk);
    logic exp;
    net_type = 2'd0; en_bss_chk = chk;
    @(negedge clk);
    check("R7 cleared by no-link", {7'd0, link_on}, 8'd0);
    net_type = nt;
    push(2'd2, to, fr, 1'b0, own_mac, 48'h0, bmatch ? bss_id : 48'h0BADBADBAD00);
    exp = chk & bmatch & (((nt == 2'd1) & !to & !fr) | ((nt == 2'd2) & !to & fr) |
                          ((nt == 2'd3) & to & !fr));
    check(chk ? "R6 link set rule" : "R10 link disabled", {7'd0, link_on}, {7'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9
    check("R9 reset rdy/vld", {6'd0, hdr_rdy, res_vld}, 8'd0);
    check("R9 reset flags", {3'd0, res_acc, res_mcast, res_bcast, res_own, link_on}, 8'd0);
    rst_n = 1;
    @(negedge clk);
    check("R8 ready after reset", {7'd0, hdr_rdy}, 8'd1);
    check("R8 idle no result", {7'd0, res_vld}, 8'd0);

    for (int cfg = 0; cfg < 32; cfg++) begin
      en_mgmt = cfg[0]; en_ctrl = cfg[1]; en_data = cfg[2]; en_pwr = cfg[3]; en_grp_a3 = cfg[4];
      for (int nt = 0; nt < 4; nt++) begin
        net_type = nt[1:0];
        for (int ft = 0; ft < 4; ft++)
          for (int pw = 0; pw < 2; pw++)
            for (int ac = 0; ac < 4; ac++)
              for (int a3m = 0; a3m < 2; a3m++) begin
                logic t_ok, p_ok, grp, a_ok, e_acc, e_bc, e_mc, e_own;
                t_ok = (ft == 0) ? cfg[0] : (ft == 1) ? cfg[1] : (ft == 2) ? cfg[2] : 1'b0;
                p_ok = (pw == 0) | cfg[3];
                grp  = (ac >= 2);
                e_bc = (ac == 3); e_mc = (ac == 2); e_own = (ac == 0);
                a_ok = grp ? (!(nt == 2 && cfg[4]) || a3m == 1) : e_own;
                e_acc = t_ok & p_ok & a_ok;
                push(ft[1:0], 1'b0, 1'b0, pw[0], addr_of(ac),
                     a3m ? own_mac : 48'h123456789A00, 48'h0);
                check("R8 result valid", {7'd0, res_vld}, 8'd1);
                check("R1 R2 R4 R5 accept", {7'd0, res_acc}, {7'd0, e_acc});
                check("R3 R4 flags", {5'd0, res_mcast, res_bcast, res_own}, {5'd0, e_mc, e_bc, e_own});
              end
      end
    end
    @(negedge clk);
    check("R8 result drops when idle", {7'd0, res_vld}, 8'd0);

    en_mgmt = 1; en_ctrl = 1; en_data = 1; en_pwr = 1; en_grp_a3 = 0;
    for (int nt = 1; nt < 4; nt++)
      for (int ds = 0; ds < 4; ds++)
        for (int bm = 0; bm < 2; bm++) begin
          link_case(nt[1:0], ds[1], ds[0], bm[0], 1'b1);
          link_case(nt[1:0], ds[1], ds[0], bm[0], 1'b0);
        end

    link_case(2'd2, 1'b0, 1'b1, 1'b1, 1'b1);
    push(2'd2, 1'b1, 1'b1, 1'b0, own_mac, 48'h0, 48'h0);
    check("R7 sticky after mismatch", {7'd0, link_on}, 8'd1);
    @(negedge clk);
    check("R7 sticky when idle", {7'd0, link_on}, 8'd1);
    net_type = 2'd0;
    push(2'd2, 1'b0, 1'b1, 1'b0, own_mac, 48'h0, bss_id);
    check("R7 clear wins over set", {7'd0, link_on}, 8'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule